// File: doc/BRIEF.md
# Pipelined zero-turnaround SRAM core

This block models a synchronous pipelined SRAM whose bus can switch between reads and writes on consecutive clocks without idle cycles. Every operation is registered on the rising clock edge. It then spends two enabled cycles in the pipeline. A read result is placed in an output register two enabled edges after its address was captured. The write data for a write is taken from the data input at the second enabled edge after its address. Because a write uses the bus in the same slot that a read would, commands of either direction can be issued every cycle.

A new operation is loaded when the load control is low and all three chip selects are active. With the load control high, the block repeats the direction of the last loaded operation at the address now on the address port. That address is supplied by an external burst counter. A clock enable freezes the whole block, including the array. Deselection and sleep stop new operations, but any operation already in the pipeline completes. The data bus is split into an input, an output and an output-enable, which the chip level combines into a tri-state pad.

The array holds `2**MEM_AW` words. It is indexed by the low `MEM_AW` address bits.

Top module: `zbt_sram_core`

## Requirements
- R1: A read loaded at enabled edge k drives its word on data_o, with data_oe_o high, after enabled edge k+2 (oe_ni low, sleep_i low).
- R2: A write loaded at enabled edge k stores the data_i value present at enabled edge k+2. Reads and writes may be loaded on consecutive cycles in any mix.
- R3: While cen_ni is high, all inputs are ignored. The pipeline, output register and array keep their values.
- R4: A new operation is loaded only when ld_ni=0, cs_a_ni=0, cs_b_i=1 and cs_c_ni=0. Any other chip-select pattern is a deselect, and the array is left unchanged.
- R5: A deselect does not cancel operations already loaded. They complete with their normal timing.
- R6: data_oe_o is low after enabled edge k+2 when the load at edge k was a deselect or a write.
- R7: rw_i=1 loads a read and rw_i=0 loads a write.
- R8: Lane j is data bits [8j+7:8j] plus parity bit 32+j. A write updates lane j only when bw_ni[j]=0.
- R9: data_oe_o is high only while oe_ni is low, sleep_i is low and a read result is held. oe_ni acts without a clock.
- R10: While sleep_i is high, no load or advance starts an operation and data_oe_o is low. Array contents are kept.
- R11: With ld_ni=1, an operation of the last loaded direction is issued at addr_i, and rw_i is ignored. No operation is issued if the last load was a deselect.
- R12: After reset, no operation is pending and data_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| cs_a_ni | input | 1 | Chip select, active low |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_ni | input | 1 | Chip select, active low |
| ld_ni | input | 1 | Low: load new operation; high: advance |
| rw_i | input | 1 | 1 read, 0 write |
| bw_ni | input | LANES | Byte-lane write selects, active low |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Output enable, active low |
| sleep_i | input | 1 | Sleep request |
| data_i | input | DATA_W | Write data (32 data + 4 parity) |
| data_o | output | DATA_W | Read data |
| data_oe_o | output | 1 | Drive enable for the data pad |

## Verification
A back-to-back write-write-read-read run separates correct two-cycle write sampling from sampling one cycle early. A read issued directly after a write to the same address checks the array update order. Runs of deselects between operations separate draining from cancelling. A frozen cycle placed mid-pipeline, with a competing write on the inputs, shows whether the freeze is complete. Advance cycles follow a read load, a write load and a deselect, each with rw_i set opposite to the expected direction. This distinguishes direction memory from direct decode of rw_i. Further cases cover partial lane masks, single wrong chip selects, the output enable and sleep.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} dir_e;
endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
  import zbt_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_ni,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             sleep_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_ni,
  output logic             s2_wr_o,
  output logic             s2_rd_o,
  output logic [AW-1:0]    s2_addr_o,
  output logic [LANES-1:0] s2_bw_no
);
  logic             last_vld_q;
  dir_e             last_dir_q;
  logic             go, new_vld;
  dir_e             new_dir;

  logic             s1_vld_q, s2_vld_q;
  dir_e             s1_dir_q, s2_dir_q;
  logic [AW-1:0]    s1_addr_q, s2_addr_q;
  logic [LANES-1:0] s1_bw_q, s2_bw_q;

  // advance reuses the direction of the last load
  always_comb begin
    go      = ld_ni ? last_vld_q : sel_i;
    new_dir = ld_ni ? last_dir_q : (rd_i ? OP_RD : OP_WR);
    new_vld = go && !sleep_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_vld_q <= 1'b0;
      last_dir_q <= OP_RD;
    end else if (en_i && !ld_ni) begin
      last_vld_q <= sel_i && !sleep_i;
      last_dir_q <= new_dir;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_dir_q  <= OP_RD;
      s1_addr_q <= '0;
      s1_bw_q   <= '1;
      s2_vld_q  <= 1'b0;
      s2_dir_q  <= OP_RD;
      s2_addr_q <= '0;
      s2_bw_q   <= '1;
    end else if (en_i) begin
      s1_vld_q  <= new_vld;
      s1_dir_q  <= new_dir;
      s1_addr_q <= addr_i;
      s1_bw_q   <= bw_ni;
      s2_vld_q  <= s1_vld_q;
      s2_dir_q  <= s1_dir_q;
      s2_addr_q <= s1_addr_q;
      s2_bw_q   <= s1_bw_q;
    end
  end

  assign s2_wr_o   = s2_vld_q && (s2_dir_q == OP_WR);
  assign s2_rd_o   = s2_vld_q && (s2_dir_q == OP_RD);
  assign s2_addr_o = s2_addr_q;
  assign s2_bw_no  = s2_bw_q;
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int unsigned AW    = 4,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [LANES-1:0]          bw_ni,
  input  logic [LANES-1:0][LW-1:0]  wdata_i,
  output logic [LANES-1:0][LW-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 2 ** AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && !bw_ni[g]) mem[addr_i] <= wdata_i[g];
    end
    assign rdata_o[g] = mem[addr_i];
  end
endmodule

// File: rtl/zbt_rdout.sv
module zbt_rdout #(
  parameter int unsigned W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         cap_i,
  input  logic [W-1:0] rdata_i,
  input  logic         oe_ni,
  input  logic         sleep_i,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic         vld_q;
  logic [W-1:0] dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      dout_q <= '0;
    end else if (en_i) begin
      vld_q <= cap_i;
      if (cap_i) dout_q <= rdata_i;
    end
  end

  assign data_o    = dout_q;
  assign data_oe_o = vld_q && !oe_ni && !sleep_i;
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core #(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned MEM_AW  = 4,
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_DW = 8,
  localparam int unsigned LW     = LANE_DW + 1,
  localparam int unsigned DATA_W = LANES * LW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              cs_a_ni,
  input  logic              cs_b_i,
  input  logic              cs_c_ni,
  input  logic              ld_ni,
  input  logic              rw_i,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int unsigned PAR_BASE = LANES * LANE_DW;

  logic                     en, sel;
  logic                     s2_wr, s2_rd;
  logic [MEM_AW-1:0]        s2_addr;
  logic [LANES-1:0]         s2_bw_n;
  logic [LANES-1:0][LW-1:0] lane_wd, lane_rd;
  logic [DATA_W-1:0]        rd_word;

  assign en  = !cen_ni;
  assign sel = !cs_a_ni && cs_b_i && !cs_c_ni;

  if (ADDR_W > MEM_AW) begin : g_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[ADDR_W-1:MEM_AW];
  end

  zbt_issue #(.AW(MEM_AW), .LANES(LANES)) u_issue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .ld_ni    (ld_ni),
    .sel_i    (sel),
    .rd_i     (rw_i),
    .sleep_i  (sleep_i),
    .addr_i   (addr_i[MEM_AW-1:0]),
    .bw_ni    (bw_ni),
    .s2_wr_o  (s2_wr),
    .s2_rd_o  (s2_rd),
    .s2_addr_o(s2_addr),
    .s2_bw_no (s2_bw_n)
  );

  // lane j = data byte j plus parity bit PAR_BASE+j
  for (genvar j = 0; j < LANES; j++) begin : g_map
    assign lane_wd[j] = {data_i[PAR_BASE+j], data_i[j*LANE_DW +: LANE_DW]};
    assign rd_word[j*LANE_DW +: LANE_DW] = lane_rd[j][LANE_DW-1:0];
    assign rd_word[PAR_BASE+j]           = lane_rd[j][LANE_DW];
  end

  zbt_array #(.AW(MEM_AW), .LANES(LANES), .LW(LW)) u_array (
    .clk_i  (clk_i),
    .we_i   (en && s2_wr),
    .addr_i (s2_addr),
    .bw_ni  (s2_bw_n),
    .wdata_i(lane_wd),
    .rdata_o(lane_rd)
  );

  zbt_rdout #(.W(DATA_W)) u_rdout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .cap_i    (s2_rd),
    .rdata_i  (rd_word),
    .oe_ni    (oe_ni),
    .sleep_i  (sleep_i),
    .data_o   (data_o),
    .data_oe_o(data_oe_o)
  );
endmodule

// File: rtl/zbt_sram_core_chk.sv
module zbt_sram_core_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              cs_a_ni,
  input logic              cs_b_i,
  input logic              cs_c_ni,
  input logic              ld_ni,
  input logic              rw_i,
  input logic              oe_ni,
  input logic              sleep_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic       sel_all, rd_load, quiet_load;
  logic [1:0] age_q;

  assign sel_all    = !cs_a_ni && cs_b_i && !cs_c_ni;
  assign rd_load    = !cen_ni && !ld_ni && sel_all && rw_i && !sleep_i;
  assign quiet_load = !cen_ni && !ld_ni && (!sel_all || !rw_i || sleep_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_rd_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(rd_load, 3) && $past(!cen_ni, 2) && $past(!cen_ni, 1)
     && !oe_ni && !sleep_i) |-> data_oe_o);

  p_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(quiet_load, 3) && $past(!cen_ni, 2) && $past(!cen_ni, 1)) |-> !data_oe_o);

  p_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable(data_o));

  p_oe_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!oe_ni && !sleep_i));

  p_sleep_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !data_oe_o);
endmodule

bind zbt_sram_core zbt_sram_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/zbt_sram_core_tb_top.sv
module zbt_sram_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cen_ni = 1'b0, cs_a_ni = 1'b1, cs_b_i = 1'b0, cs_c_ni = 1'b1;
  logic        ld_ni = 1'b1, rw_i = 1'b1, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [3:0]  bw_ni = 4'hF;
  logic [18:0] addr_i = '0;
  logic [35:0] data_i = '0;
  logic [35:0] data_o;
  logic        data_oe_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  zbt_sram_core dut_i (.*);

  typedef struct packed {
    logic        cen_n, ld_n, sel, rd;
    logic [3:0]  bw_n;
    logic [3:0]  addr;
    logic [35:0] wd;
    logic        exp_oe;
    logic [35:0] exp_d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,4'h0,4'd1,36'h0,        1'b0,36'h0,         4'd12}, // 0 W A1, R12
    '{1'b0,1'b0,1'b1,1'b0,4'h0,4'd2,36'h0,        1'b0,36'h0,         4'd12}, // 1 W A2
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd1,36'h111111111,1'b0,36'h0,         4'd6},  // 2 R A1, data A1 (R2)
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd2,36'h222222222,1'b0,36'h0,         4'd6},  // 3 R A2
    '{1'b0,1'b0,1'b1,1'b0,4'h0,4'd3,36'h0,        1'b1,36'h111111111, 4'd1},  // 4 W A3, R1
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd3,36'h0,        1'b1,36'h222222222, 4'd7},  // 5 R A3, R7
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h333333333,1'b0,36'h0,         4'd6},  // 6 desel
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b1,36'h333333333, 4'd5},  // 7 drain, R5
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd6},  // 8
    '{1'b0,1'b0,1'b1,1'b0,4'hA,4'd1,36'h0,        1'b0,36'h0,         4'd6},  // 9 partial W A1 lanes 0,2
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd6},  // 10
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'hFFFFFFFFF,1'b0,36'h0,         4'd6},  // 11
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd1,36'h0,        1'b0,36'h0,         4'd6},  // 12 R A1
    '{1'b1,1'b0,1'b1,1'b0,4'h0,4'd2,36'h0AAAAAAAA,1'b0,36'h0,         4'd3},  // 13 frozen W A2, R3
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd3},  // 14
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b1,36'h511FF11FF, 4'd8},  // 15 R8
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd2,36'h0,        1'b0,36'h0,         4'd6},  // 16 R A2
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd3},  // 17
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b1,36'h222222222, 4'd3},  // 18 A2 kept, R3
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd3,36'h0,        1'b0,36'h0,         4'd6},  // 19 R A3
    '{1'b0,1'b1,1'b1,1'b0,4'hF,4'd1,36'h0,        1'b0,36'h0,         4'd6},  // 20 advance A1, rw_i=0
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b1,36'h333333333, 4'd1},  // 21
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b1,36'h511FF11FF, 4'd11}, // 22 R11
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd6},  // 23
    '{1'b0,1'b0,1'b1,1'b0,4'h0,4'd4,36'h0,        1'b0,36'h0,         4'd6},  // 24 W A4
    '{1'b0,1'b1,1'b1,1'b1,4'h0,4'd5,36'h0,        1'b0,36'h0,         4'd6},  // 25 advance A5, rw_i=1
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h444444444,1'b0,36'h0,         4'd6},  // 26
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h555555555,1'b0,36'h0,         4'd6},  // 27
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd4,36'h0,        1'b0,36'h0,         4'd6},  // 28 R A4
    '{1'b0,1'b0,1'b1,1'b1,4'hF,4'd5,36'h0,        1'b0,36'h0,         4'd6},  // 29 R A5
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b1,36'h444444444, 4'd2},  // 30 R2
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b1,36'h555555555, 4'd11}, // 31 R11 write advance
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd6},  // 32 desel load
    '{1'b0,1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,        1'b0,36'h0,         4'd6},  // 33 advance after desel
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd6},  // 34
    '{1'b0,1'b0,1'b0,1'b0,4'hF,4'd0,36'h0,        1'b0,36'h0,         4'd11}  // 35 none issued, R11
  };

  task automatic check(input string tag, input logic eoe, input logic [35:0] ed);
    checks++;
    if (data_oe_o !== eoe || (eoe && data_o !== ed)) begin
      fails++;
      $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
               tag, data_oe_o, data_o, eoe, ed);
    end
  endtask

  task automatic cyc(input logic cen_n, input logic ld_n, input logic a_n, input logic b,
                     input logic c_n, input logic rd, input logic [3:0] bw_n,
                     input logic [3:0] addr, input logic [35:0] wd);
    cen_ni = cen_n; ld_ni = ld_n; cs_a_ni = a_n; cs_b_i = b; cs_c_ni = c_n;
    rw_i = rd; bw_ni = bw_n; addr_i = {15'b0, addr}; data_i = wd;
    @(posedge clk_i);
    #2;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 4'd0, 36'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    check("R12 reset", 1'b0, 36'h0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'd0, 36'h0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'd0, 36'h0);
    check("R12 idle advance", 1'b0, 36'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      cyc(v.cen_n, v.ld_n, !v.sel, v.sel, !v.sel, v.rd, v.bw_n, v.addr, v.wd);
      check($sformatf("R%0d row %0d", v.req, i), v.exp_oe, v.exp_d);
    end

    // R4: one wrong chip select blocks the write
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 4'd1, 36'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 4'd2, 36'h0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 4'd0, 36'h0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 4'd0, 36'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'd1, 36'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'd2, 36'h0);
    idle();
    check("R4 A1 unchanged", 1'b1, 36'h511FF11FF);
    idle();
    check("R4 A2 unchanged", 1'b1, 36'h222222222);

    // R9: asynchronous output enable
    oe_ni = 1'b1; #1;
    check("R9 oe_ni high", 1'b0, 36'h0);
    oe_ni = 1'b0; #1;
    check("R9 oe_ni low", 1'b1, 36'h222222222);

    // R10: sleep
    sleep_i = 1'b1; #1;
    check("R10 sleep hiz", 1'b0, 36'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 4'd1, 36'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'd1, 36'h0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 4'd0, 36'h0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 4'd0, 36'h0);
    sleep_i = 1'b0; #1;
    check("R10 no read issued", 1'b0, 36'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'd1, 36'h0);
    idle();
    idle();
    check("R10 contents kept", 1'b1, 36'h511FF11FF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule